// File: doc/BRIEF.md
# One-Time-Programmable Identification Register

This block holds a 128-bit identification value split into two 64-bit halves. The factory half comes from a parameter and is loaded at reset. No write can change it. The user half resets blank, with every bit at one. Writes to it may only clear bits, and a single lock request closes it to any further change. A host can match the value against other parts of the system, so that a substituted device can be detected.

Reads go through an identifier window of nine 16-bit words. A `id_mode` input stands in for the command decoder. While it is low the read port returns zero. A program error flag reports whether the most recent program request was refused. Keeping the contents across power cycles is outside this block. Reset reloads the factory value, blanks the user half and clears the lock.

Top module: `otp_prot_reg`

## Requirements
- R1: After reset the user words read 0xFFFF, the lock word reads 0xFFFE and `pgm_err` is 0.
- R2: Offsets 0x81 to 0x84 read the factory words. Offset 0x81 returns bits 15:0 of `FACTORY_ID` and offset 0x84 returns bits 63:48.
- R3: `rd_data` is registered. At each rising edge it takes the word addressed by `rd_addr` when `id_mode` is 1, and takes 0 when `id_mode` is 0.
- R4: Addresses below 0x80 and above 0x88 read 0.
- R5: A program request to a user word at offset 0x85 to 0x88 while the register is unlocked replaces that word with the old value AND `pgm_data`, and clears `pgm_err`.
- R6: A program request to offset 0x80 through 0x84, or to any address outside 0x80 to 0x88, changes no word and sets `pgm_err`.
- R7: After a lock request, every program request is refused: no word changes and `pgm_err` is set.
- R8: In the lock word, bit 1 is 1 while unlocked and 0 once locked, bit 0 is always 0 and bits 15:2 are always 1. The lock stays in place until reset, which clears it and blanks the user words.
- R9: When a lock request and a program request arrive in the same cycle, the program request is judged against the state before the lock and takes effect.
- R10: `pgm_err` changes only on a cycle with a program request. Lock requests and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| id_mode | input | 1 | High while the device is in identifier read mode |
| rd_addr | input | 8 | Identifier read address |
| rd_data | output | 16 | Registered read word |
| pgm_req | input | 1 | One-cycle program request |
| pgm_addr | input | 8 | Program target address |
| pgm_data | input | 16 | Program data, ANDed into the target word |
| lock_req | input | 1 | One-cycle request to lock the user half |
| pgm_err | output | 1 | Outcome of the last program request, 1 if refused |

## Verification
The bench keeps the default word width and window base. It overrides `FACTORY_ID` with a pattern in which each factory word has a distinct value, so that a swapped word order or a wrong half shows up as a wrong read value. With the default four words per half, the program decoder's boundaries are reached directly. These are the last factory word, the first and last user words, and the addresses just outside the window. A repeated program to one user word shows that writes can only clear bits.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LOCK = 2'd1,
    SEL_FACT = 2'd2,
    SEL_USER = 2'd3
  } win_sel_e;
endpackage

// File: rtl/otp_win_decode.sv
module otp_win_decode
  import otp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE      = 'h80,
  parameter int SEG_WORDS = 4,
  localparam int IDX_W    = $clog2(SEG_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output win_sel_e          sel,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] SW     = ADDR_W'(SEG_WORDS);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] rel;

  always_comb begin
    off = addr - BASE_A;
    rel = off - ADDR_W'(1);
    sel = SEL_NONE;
    idx = '0;
    if (addr >= BASE_A) begin
      if (off == '0) begin
        sel = SEL_LOCK;
      end else if (off <= SW) begin
        sel = SEL_FACT;
        idx = rel[IDX_W-1:0];
      end else if (off <= (SW << 1)) begin
        sel = SEL_USER;
        idx = IDX_W'(rel - SW);
      end
    end
  end
endmodule

// File: rtl/otp_user_store.sv
module otp_user_store #(
  parameter int WORD_W    = 16,
  parameter int SEG_WORDS = 4,
  localparam int IDX_W    = $clog2(SEG_WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [WORD_W-1:0]           wr_data,
  input  logic                        lock_set,
  output logic                        locked,
  output logic [SEG_WORDS*WORD_W-1:0] words
);
  logic [WORD_W-1:0] word_q [SEG_WORDS];
  logic [WORD_W-1:0] word_d [SEG_WORDS];
  logic              lock_q, lock_d;
  logic              apply;

  always_comb begin
    apply  = wr_en && !lock_q;
    lock_d = lock_q | lock_set;
    for (int i = 0; i < SEG_WORDS; i++) begin
      word_d[i] = word_q[i];
      if (apply && (wr_idx == IDX_W'(i))) word_d[i] = word_q[i] & wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      for (int i = 0; i < SEG_WORDS; i++) word_q[i] <= '1;
    end else begin
      lock_q <= lock_d;
      if (apply) begin
        for (int i = 0; i < SEG_WORDS; i++) word_q[i] <= word_d[i];
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < SEG_WORDS; g++) begin : g_out
      assign words[g*WORD_W +: WORD_W] = word_q[g];
      // R5: bits only ever fall from 1 to 0
      a_r5_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        (word_q[g] & ~$past(word_q[g])) == '0);
    end
  endgenerate

  assign locked = lock_q;

  a_r7_frozen_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(words));
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
endmodule

// File: rtl/otp_prot_reg.sv
module otp_prot_reg
  import otp_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int BASE      = 'h80,
  parameter int SEG_WORDS = 4,
  parameter logic [WORD_W*SEG_WORDS-1:0] FACTORY_ID = 64'hC3A5_0F1E_7D62_9B48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              pgm_req,
  input  logic [ADDR_W-1:0] pgm_addr,
  input  logic [WORD_W-1:0] pgm_data,
  input  logic              lock_req,
  output logic              pgm_err
);
  localparam int IDX_W = $clog2(SEG_WORDS);
  localparam int SEG_W = WORD_W * SEG_WORDS;

  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic [SEG_W-1:0] fact_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) fact_q <= FACTORY_ID;
    else          fact_q <= fact_q;
  end

  win_sel_e         rd_sel, pg_sel;
  logic [IDX_W-1:0] rd_idx, pg_idx;

  otp_win_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .SEG_WORDS(SEG_WORDS)) u_rd_dec (
    .addr(rd_addr), .sel(rd_sel), .idx(rd_idx));
  otp_win_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .SEG_WORDS(SEG_WORDS)) u_pg_dec (
    .addr(pgm_addr), .sel(pg_sel), .idx(pg_idx));

  logic             locked;
  logic [SEG_W-1:0] user_words;
  logic             user_wr;

  assign user_wr = pgm_req && (pg_sel == SEL_USER);

  otp_user_store #(.WORD_W(WORD_W), .SEG_WORDS(SEG_WORDS)) u_user (
    .clk(clk), .rst_n(rst_s_n), .wr_en(user_wr), .wr_idx(pg_idx),
    .wr_data(pgm_data), .lock_set(lock_req), .locked(locked), .words(user_words));

  logic [WORD_W-1:0] rd_d;
  logic              err_d;

  always_comb begin
    rd_d = '0;
    if (id_mode) begin
      unique case (rd_sel)
        SEL_LOCK: rd_d = {{(WORD_W-2){1'b1}}, ~locked, 1'b0};
        SEL_FACT: rd_d = fact_q[rd_idx*WORD_W +: WORD_W];
        SEL_USER: rd_d = user_words[rd_idx*WORD_W +: WORD_W];
        default:  rd_d = '0;
      endcase
    end
    err_d = pgm_err;
    if (pgm_req) err_d = (pg_sel != SEL_USER) || locked;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rd_data <= '0;
      pgm_err <= 1'b0;
    end else begin
      rd_data <= rd_d;
      if (pgm_req) pgm_err <= err_d;
    end
  end

  a_r3_idle_reads_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    !id_mode |=> rd_data == '0);
  a_r6_factory_refused: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pgm_req && pg_sel == SEL_FACT) |=> pgm_err);
  a_r5_good_program_clears: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pgm_req && pg_sel == SEL_USER && !locked) |=> !pgm_err);
  a_r10_err_holds: assert property (@(posedge clk) disable iff (!rst_s_n)
    !pgm_req |=> $stable(pgm_err));
endmodule

// File: tb/otp_prot_reg_test.sv
module otp_prot_reg_test;
  localparam logic [63:0] FID = 64'h1234_5678_9ABC_DEF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_mode = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        pgm_req = 1'b0;
  logic [7:0]  pgm_addr = '0;
  logic [15:0] pgm_data = '0;
  logic        lock_req = 1'b0;
  logic        pgm_err;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  otp_prot_reg #(.FACTORY_ID(FID)) uut (
    .clk(clk), .rst_n(rst_n), .id_mode(id_mode), .rd_addr(rd_addr),
    .rd_data(rd_data), .pgm_req(pgm_req), .pgm_addr(pgm_addr),
    .pgm_data(pgm_data), .lock_req(lock_req), .pgm_err(pgm_err));

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic prog(input logic [7:0] a, input logic [15:0] v, input logic lk);
    pgm_req = 1'b1; pgm_addr = a; pgm_data = v; lock_req = lk;
    @(posedge clk);
    @(negedge clk);
    pgm_req = 1'b0; lock_req = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    id_mode = 1'b1;
    check("R1 pgm_err", {15'd0, pgm_err}, 16'h0);
    for (int a = 'h85; a <= 'h88; a++) begin
      rd(8'(a), d); check("R1 user blank", d, 16'hFFFF);
    end
    rd(8'h80, d); check("R1 R8 lock word unlocked", d, 16'hFFFE);
  endtask

  task automatic t_factory();
    logic [15:0] d;
    for (int i = 0; i < 4; i++) begin
      rd(8'('h81 + i), d); check("R2 factory word", d, FID[i*16 +: 16]);
    end
  endtask

  task automatic t_mode_gate();
    logic [15:0] d;
    id_mode = 1'b0;
    rd(8'h81, d); check("R3 mode off factory", d, 16'h0);
    rd(8'h85, d); check("R3 mode off user", d, 16'h0);
    id_mode = 1'b1;
    rd(8'h82, d); check("R3 mode on", d, FID[31:16]);
  endtask

  task automatic t_outside();
    logic [15:0] d;
    rd(8'h7F, d); check("R4 below", d, 16'h0);
    rd(8'h89, d); check("R4 above", d, 16'h0);
    rd(8'h00, d); check("R4 zero", d, 16'h0);
  endtask

  task automatic t_program();
    logic [15:0] d;
    prog(8'h85, 16'hF0F0, 1'b0);
    check("R5 err clear", {15'd0, pgm_err}, 16'h0);
    rd(8'h85, d); check("R5 first program", d, 16'hF0F0);
    prog(8'h85, 16'h0FFF, 1'b0);
    rd(8'h85, d); check("R5 and-only", d, 16'h00F0);
    prog(8'h88, 16'h1234, 1'b0);
    rd(8'h88, d); check("R5 last user word", d, 16'h1234);
  endtask

  task automatic t_refused();
    logic [15:0] d;
    prog(8'h84, 16'h0000, 1'b0);
    check("R6 factory err", {15'd0, pgm_err}, 16'h1);
    rd(8'h84, d); check("R6 factory intact", d, FID[63:48]);
    repeat (3) @(negedge clk);
    check("R10 err held idle", {15'd0, pgm_err}, 16'h1);
    prog(8'h86, 16'hFFFF, 1'b0);
    check("R5 err cleared", {15'd0, pgm_err}, 16'h0);
    prog(8'h89, 16'h0000, 1'b0);
    check("R6 outside err", {15'd0, pgm_err}, 16'h1);
    prog(8'h80, 16'h0000, 1'b0);
    check("R6 lock word err", {15'd0, pgm_err}, 16'h1);
    rd(8'h80, d); check("R6 lock word intact", d, 16'hFFFE);
  endtask

  task automatic t_lock();
    logic [15:0] d;
    prog(8'h86, 16'hAAAA, 1'b1);
    check("R9 same-cycle ok", {15'd0, pgm_err}, 16'h0);
    rd(8'h86, d); check("R9 same-cycle applied", d, 16'hAAAA);
    rd(8'h80, d); check("R8 lock word locked", d, 16'hFFFC);
    prog(8'h87, 16'h0000, 1'b0);
    check("R7 refused err", {15'd0, pgm_err}, 16'h1);
    rd(8'h87, d); check("R7 word intact", d, 16'hFFFF);
    prog(8'h86, 16'h0000, 1'b0);
    rd(8'h86, d); check("R7 programmed word intact", d, 16'hAAAA);
    lock_req = 1'b1; @(posedge clk); @(negedge clk); lock_req = 1'b0;
    check("R10 lock keeps err", {15'd0, pgm_err}, 16'h1);
    rd(8'h80, d); check("R8 still locked", d, 16'hFFFC);
  endtask

  task automatic t_reload();
    logic [15:0] d;
    do_reset();
    id_mode = 1'b1;
    rd(8'h80, d); check("R8 reset unlocks", d, 16'hFFFE);
    rd(8'h86, d); check("R8 reset blanks", d, 16'hFFFF);
    rd(8'h81, d); check("R2 factory reloaded", d, FID[15:0]);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_factory();
    t_mode_gate();
    t_outside();
    t_program();
    t_refused();
    t_lock();
    t_reload();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule